// File: doc/BRIEF.md
# Synthesizer frequency word encoder

This block turns a requested pixel-clock period, given in picoseconds, into the 13-bit programming word for a serially loaded clock synthesizer that has a selectable power-of-two post-divider. A one-cycle start pulse captures the period. The block then derives the frequency in units of 0.01 MHz and rejects values outside the synthesizer's usable range. It doubles the frequency until it lies in the synthesizer's top octave, which also sets the post-divide ratio. It scales the result by the fixed feedback-to-reference ratio with rounding, removes a constant offset, and packs the result with the divider code and the fixed stop pattern.

All three divisions share one 32-bit restoring divider, so a conversion takes many cycles. A one-cycle done pulse marks each result, and an error flag is valid from that pulse onward. Serial shifting of the word to the synthesizer happens elsewhere.

Top module: `synth_freq_encoder`

## Requirements
- R1: The frequency is the truncated integer quotient 100000000 / period (0.01 MHz units). A period of 0 counts as an out-of-range frequency.
- R2: If the frequency is above 15938 or below 1000, the result has err_o = 1. In that case word_o and post_div_o keep the values they had before.
- R3: Starting from ratio 1, while the frequency is below 8000 it is doubled and the ratio is doubled. post_div_o reports the final ratio as the value 1, 2, 4 or 8.
- R4: word_o[8:0] equals ((floor(f*46000/1432) + 500) / 1000) - 257, where f is the doubled frequency. This value never exceeds 257.
- R5: word_o[10:9] is 3 for ratio 1, 2 for ratio 2, 1 for ratio 4 and 0 for ratio 8.
- R6: word_o[12:11] is 2'b11 in every valid result.
- R7: Each accepted start yields exactly one done_o pulse one cycle long. A valid result clears err_o.
- R8: A start pulse that arrives while a conversion is in progress is ignored and produces no extra result.
- R9: word_o and post_div_o change only in a cycle in which done_o is high.
- R10: After reset, word_o = 0, post_div_o = 0, err_o = 0 and done_o = 0.
- R11: done_o rises 34 clock edges after the start edge for a rejected frequency. For a valid one it rises after 101 + k edges, where k is the number of doublings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to convert period_ps_i |
| period_ps_i | input | 32 | Requested pixel-clock period in ps |
| word_o | output | 13 | Synthesizer programming word |
| post_div_o | output | 4 | Chosen post-divide ratio (1, 2, 4, 8) |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Last request was out of range |

## Verification
The periods are chosen to sit on each side of the upper and lower frequency limits. This separates an off-by-one compare from a correct one, and a period of zero shows how the quotient of a zero divisor is handled. Periods that give frequencies of exactly 8000 and 7999, and frequencies that need two and three doublings, show whether the octave loop stops at the right point and emits the matching divider code. A rejected request placed directly after a valid one shows that the previous word survives an error. A second start injected mid-conversion shows that requests made while busy are dropped. Every result is also timed against its expected edge count.

// File: rtl/sfe_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and FSM state type for the frequency word encoder.
// Assumes a 32-bit datapath wide enough for 100e6 and for f*46000 with f < 16000.
package sfe_pkg;
    localparam int DIV_W      = 32;
    localparam int PERIOD_NUM = 100_000_000;
    localparam int F_MAX      = 15938;
    localparam int F_MIN      = 1000;
    localparam int F_OCT      = 8000;
    localparam int REF_MUL    = 46;
    localparam int REF_DEN    = 1432;
    localparam int SCALE      = 1000;
    localparam int ROUND_ADD  = SCALE / 2;
    localparam int N_OFFSET   = 257;
    localparam int LOW_W      = 9;
    localparam int RATIO_W    = 4;
    localparam int CODE_W     = $clog2(RATIO_W);
    localparam int STOP_W     = 2;
    localparam int WORD_W     = STOP_W + CODE_W + LOW_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FDIV,
        ST_RANGE,
        ST_NORM,
        ST_SDIV,
        ST_RDIV
    } sfe_state_t;
endpackage

// File: rtl/sfe_divider.sv
`timescale 1ns/1ps
// Module: restoring unsigned divider, one quotient bit per cycle.
// Assumes start_i is only raised when idle; done_o pulses W cycles after the
// load edge. A zero divisor yields an all-ones quotient.
module sfe_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] quo_o,
    output logic         done_o
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     quo_q;
    logic [W-1:0]     den_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic [W:0]       shifted;
    logic [W:0]       trial;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    // Load operands, then iterate W restoring steps and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (start_i) begin
            rem_q  <= '0;
            quo_q  <= num_i;
            den_q  <= den_i;
            cnt_q  <= CNT_W'(W);
            done_q <= 1'b0;
        end else if (cnt_q != '0) begin
            if (!trial[W]) begin
                rem_q <= trial[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q  <= cnt_q - CNT_W'(1);
            done_q <= (cnt_q == CNT_W'(1));
        end else begin
            done_q <= 1'b0;
        end
    end

    assign quo_o  = quo_q;
    assign done_o = done_q;
endmodule

// File: rtl/sfe_octave_step.sv
`timescale 1ns/1ps
// Module: one octave-normalisation step. Reports whether the frequency is
// still below the octave floor and gives the doubled frequency and ratio.
// Assumes the ratio is one-hot and the frequency leaves headroom for a shift.
module sfe_octave_step
    import sfe_pkg::*;
(
    input  logic [DIV_W-1:0]   freq_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               need_dbl_o,
    output logic [DIV_W-1:0]   freq_next_o,
    output logic [RATIO_W-1:0] ratio_next_o
);
    // Compare against the octave floor and form the doubled values.
    always_comb begin
        need_dbl_o   = (freq_i < DIV_W'(F_OCT));
        freq_next_o  = freq_i << 1;
        ratio_next_o = ratio_i << 1;
    end
endmodule

// File: rtl/sfe_word_pack.sv
`timescale 1ns/1ps
// Module: assembles the programming word from the low field, the post-divide
// code (highest code for ratio 1, zero for the largest ratio) and stop bits.
// Assumes ratio_i is one-hot.
module sfe_word_pack
    import sfe_pkg::*;
(
    input  logic [LOW_W-1:0]   low_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [WORD_W-1:0]  word_o
);
    logic [CODE_W-1:0] code;

    // Map the one-hot ratio bit position onto its inverted code.
    always_comb begin
        code = '0;
        for (int i = 0; i < RATIO_W; i++) begin
            if (ratio_i[i]) code = CODE_W'(RATIO_W - 1 - i);
        end
    end

    // Concatenate stop pattern, divider code and low field.
    always_comb begin
        word_o = {{STOP_W{1'b1}}, code, low_i};
    end
endmodule

// File: rtl/synth_freq_encoder.sv
`timescale 1ns/1ps
// Module: period-to-programming-word encoder for a post-divided synthesizer.
// Sequences three passes through one shared divider: frequency, scaled
// value, rounded value. Assumes start_i is a single-cycle pulse; starts while
// busy are dropped. Outputs hold until the next done pulse; an error leaves
// word and ratio untouched.
module synth_freq_encoder
    import sfe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [DIV_W-1:0]    period_ps_i,
    output logic [WORD_W-1:0]   word_o,
    output logic [RATIO_W-1:0]  post_div_o,
    output logic                done_o,
    output logic                err_o
);
    sfe_state_t         state_q;
    logic [DIV_W-1:0]   freq_q;
    logic [RATIO_W-1:0] ratio_q;

    logic               div_start;
    logic [DIV_W-1:0]   div_num;
    logic [DIV_W-1:0]   div_den;
    logic [DIV_W-1:0]   div_quo;
    logic               div_done;

    logic               need_dbl;
    logic [DIV_W-1:0]   freq_next;
    logic [RATIO_W-1:0] ratio_next;
    logic               freq_bad;
    logic [LOW_W-1:0]   low_field;
    logic [WORD_W-1:0]  packed_word;

    sfe_divider #(.W(DIV_W)) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (div_den),
        .quo_o   (div_quo),
        .done_o  (div_done)
    );

    sfe_octave_step oct_i (
        .freq_i       (freq_q),
        .ratio_i      (ratio_q),
        .need_dbl_o   (need_dbl),
        .freq_next_o  (freq_next),
        .ratio_next_o (ratio_next)
    );

    sfe_word_pack pack_i (
        .low_i   (low_field),
        .ratio_i (ratio_q),
        .word_o  (packed_word)
    );

    // Range test on the captured frequency and offset removal on the last quotient.
    always_comb begin
        freq_bad  = (freq_q > DIV_W'(F_MAX)) || (freq_q < DIV_W'(F_MIN));
        low_field = div_quo[LOW_W-1:0] - LOW_W'(N_OFFSET);
    end

    // Choose divider operands and launch point for each pass.
    always_comb begin
        div_start = 1'b0;
        div_num   = DIV_W'(PERIOD_NUM);
        div_den   = period_ps_i;
        case (state_q)
            ST_IDLE: div_start = start_i;
            ST_NORM: begin
                if (!need_dbl) begin
                    div_start = 1'b1;
                    div_num   = freq_q * DIV_W'(REF_MUL * SCALE);
                    div_den   = DIV_W'(REF_DEN);
                end
            end
            ST_SDIV: begin
                if (div_done) begin
                    div_start = 1'b1;
                    div_num   = div_quo + DIV_W'(ROUND_ADD);
                    div_den   = DIV_W'(SCALE);
                end
            end
            default: ;
        endcase
    end

    // Conversion sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            freq_q     <= '0;
            ratio_q    <= '0;
            word_o     <= '0;
            post_div_o <= '0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) state_q <= ST_FDIV;
                ST_FDIV: begin
                    if (div_done) begin
                        freq_q  <= div_quo;
                        state_q <= ST_RANGE;
                    end
                end
                ST_RANGE: begin
                    if (freq_bad) begin
                        err_o   <= 1'b1;
                        done_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        ratio_q <= RATIO_W'(1);
                        state_q <= ST_NORM;
                    end
                end
                ST_NORM: begin
                    if (need_dbl) begin
                        freq_q  <= freq_next;
                        ratio_q <= ratio_next;
                    end else begin
                        state_q <= ST_SDIV;
                    end
                end
                ST_SDIV: if (div_done) state_q <= ST_RDIV;
                ST_RDIV: begin
                    if (div_done) begin
                        word_o     <= packed_word;
                        post_div_o <= ratio_q;
                        err_o      <= 1'b0;
                        done_o     <= 1'b1;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/synth_freq_encoder_chk.sv
`timescale 1ns/1ps
// Module: property checker for the frequency word encoder, bound to the top.
// Assumes synchronous active-low reset; history checks wait one edge after reset.
module synth_freq_encoder_chk
    import sfe_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [WORD_W-1:0]   word_o,
    input logic [RATIO_W-1:0]  post_div_o,
    input logic                done_o,
    input logic                err_o
);
    logic armed;

    // Marks that one post-reset edge has passed, so $past/$stable are meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_stop_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (word_o[WORD_W-1 -: STOP_W] == {STOP_W{1'b1}}));

    assert_ratio_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> ($countones(post_div_o) == 1));

    assert_code_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |->
        ((post_div_o == 4'd1 && word_o[10:9] == 2'd3) ||
         (post_div_o == 4'd2 && word_o[10:9] == 2'd2) ||
         (post_div_o == 4'd4 && word_o[10:9] == 2'd1) ||
         (post_div_o == 4'd8 && word_o[10:9] == 2'd0)));

    assert_low_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (word_o[LOW_W-1:0] <= LOW_W'(N_OFFSET)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !done_o |-> ($stable(word_o) && $stable(post_div_o)));

    assert_err_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (done_o && err_o) |-> ($stable(word_o) && $stable(post_div_o)));
endmodule

bind synth_freq_encoder synth_freq_encoder_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_o     (word_o),
    .post_div_o (post_div_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/synth_freq_encoder_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver predicts each result and queues it, the
// monitor compares every done pulse against the head of the queue.
module synth_freq_encoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] period_ps_i = '0;
    logic [12:0] word_o;
    logic [3:0]  post_div_o;
    logic        done_o;
    logic        err_o;

    typedef struct {
        logic [12:0] w;
        logic [3:0]  r;
        logic        e;
        longint      due;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    longint      cyc = 0;
    logic        mon_en = 1'b0;
    logic        finished = 1'b0;
    logic [12:0] model_w = '0;
    logic [3:0]  model_r = '0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    synth_freq_encoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .period_ps_i (period_ps_i),
        .word_o      (word_o),
        .post_div_o  (post_div_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // Expected result from the requirements (R1..R5, R11).
    task automatic predict(input logic [31:0] p, input string req);
        exp_t x;
        longint f;
        longint q;
        int k;
        logic [1:0] code;
        f = (p == 0) ? 64'hFFFF_FFFF : (100000000 / p);
        x.req = req;
        if (f > 15938 || f < 1000) begin
            x.e = 1'b1; x.w = model_w; x.r = model_r;
            x.due = cyc + 1 + 34;
        end else begin
            k = 0; x.r = 4'd1;
            while (f < 8000) begin f = f * 2; x.r = x.r << 1; k++; end
            q = (f * 46000) / 1432;
            q = (q + 500) / 1000;
            case (x.r)
                4'd1: code = 2'd3;
                4'd2: code = 2'd2;
                4'd4: code = 2'd1;
                default: code = 2'd0;
            endcase
            x.w = {2'b11, code, 9'(q - 257)};
            x.e = 1'b0;
            x.due = cyc + 1 + 101 + k;
            model_w = x.w; model_r = x.r;
        end
        sb_q.push_back(x);
    endtask

    task automatic apply(input logic [31:0] p, input string req);
        @(negedge clk);
        predict(p, req);
        period_ps_i = p;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait (sb_q.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare results, single-cycle done (R7), hold between pulses (R9).
    logic        prev_done = 1'b0;
    logic [12:0] prev_w = '0;
    logic [3:0]  prev_r = '0;
    always @(negedge clk) begin : mon
        exp_t x;
        if (mon_en) begin
            if (done_o) begin
                check(!prev_done, "R7 done width", 1, 0);
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8 unexpected result", 1, 0);
                end else begin
                    x = sb_q.pop_front();
                    check(word_o == x.w, {x.req, " word"}, word_o, x.w);
                    check(post_div_o == x.r, {x.req, " ratio"}, post_div_o, x.r);
                    check(err_o == x.e, {x.req, " err"}, err_o, x.e);
                    check(cyc == x.due, "R11 latency", cyc, x.due);
                end
            end else begin
                check(word_o == prev_w && post_div_o == prev_r, "R9 hold",
                      {word_o, post_div_o}, {prev_w, prev_r});
            end
            prev_done = done_o;
            prev_w = word_o;
            prev_r = post_div_o;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(word_o == 0, "R10 word", word_o, 0);
        check(post_div_o == 0, "R10 ratio", post_div_o, 0);
        check(err_o == 0 && done_o == 0, "R10 flags", {err_o, done_o}, 0);
        mon_en = 1'b1;

        apply(32'd10000,  "R1 R4 R6 nominal");
        apply(32'd6274,   "R2 upper edge accepted");
        apply(32'd6273,   "R2 above upper limit");
        apply(32'd100000, "R3 R5 ratio 8 lower edge");
        apply(32'd100001, "R2 below lower limit");
        apply(32'd12500,  "R3 octave floor no doubling");
        apply(32'd12501,  "R3 R5 one doubling");
        apply(32'd0,      "R1 R2 zero period");
        apply(32'd50000,  "R3 R5 ratio 4");
        apply(32'd7000,   "R4 R7 err cleared");
        apply(32'd25000,  "R5 ratio 2");

        // R8: second start mid-conversion is dropped
        @(negedge clk);
        predict(32'd9000, "R8 first request kept");
        period_ps_i = 32'd9000;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        period_ps_i = 32'd0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait (sb_q.size() == 0);
        repeat (150) @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule